// File: doc/BRIEF.md
# ADC Power-Up Configuration Sequencer

This block is a control state machine that brings a multichannel serial-output ADC out of reset. It first puts the converter into a deskew test-pattern mode so that downstream lane capture logic can align to a known pattern. When that logic reports alignment, the block returns the converter to normal conversion mode. It drives the converter's sampling-clock enable, its hardware reset pin, its transmit-trigger pin and its power-down pin. Register writes go out through a small internal SPI serializer.

Phase one always follows the same order. The sampling clock is enabled, a timed reset pulse is driven, five register frames are written in a fixed list order, and then a timed trigger pulse is driven. The block then reports that the pattern is ready and waits for `align_done`. Phase two sends a single frame that rewrites the pattern-select register and does nothing else. There is no second trigger pulse, so the data-to-clock delay set by the first trigger is kept. All millisecond timing is counted in system-clock cycles through the `CLKS_PER_MS` parameter. A synchronous `restart` input replays the whole sequence.

The block has no streaming data path. Every pin is a plain level or pulse control, so no valid/ready handshake or back-pressure rules apply.

Top module: `adc_bringup_seq`

## Requirements
- R1: While `rst_n` is low, `samp_clk_en`, `adc_reset`, `adc_trig`, `spi_sclk`, `pattern_ready` and `normal_ready` are 0, and `spi_csn` and `busy` are 1. After reset, `samp_clk_en` rises first, and `adc_reset` rises exactly one cycle later.
- R2: `adc_reset` stays high for exactly `PULSE_MS*CLKS_PER_MS` cycles.
- R3: Each register write is one frame of 24 bits: an 8-bit address and then 16-bit data, most significant bit first. `spi_csn` is low for the whole frame. `spi_mosi` is stable while `spi_sclk` is high and is sampled on the rising edge of `spi_sclk`. Each high phase of `spi_sclk` lasts `SCLK_HALF` cycles.
- R4: Phase one sends exactly these five frames, in this order: (0x0A, 0x3000), (0x02, 0x4100), (0x03, 0x0000), (0x04, 0x0000), (0x01, 0x0000). The first frame starts only after `adc_reset` has fallen. Consecutive frames are separated by at least `GAP_CYCLES` cycles with `spi_csn` high.
- R5: After the last phase-one frame and its gap, `adc_trig` goes high with `spi_csn` high and stays high for exactly `PULSE_MS*CLKS_PER_MS` cycles. `pattern_ready` rises in the same cycle that `adc_trig` falls.
- R6: `align_done` is ignored unless `pattern_ready` is high. When it is ignored, no frame is sent and the ready outputs do not change.
- R7: An `align_done` seen while `pattern_ready` is high produces exactly one frame, (0x02, `NORMAL_WORD`), and no further `adc_trig` pulse. `pattern_ready` drops in the next cycle.
- R8: `normal_ready` rises once the phase-two frame and its gap have completed, with `spi_csn` high. `busy` is 0 exactly when `pattern_ready` or `normal_ready` is 1.
- R9: `adc_pdn` is 0 at all times.
- R10: `restart` is synchronous. In the cycle after it is seen, `samp_clk_en`, `adc_reset` and `adc_trig` are 0, `spi_csn` is 1 and `busy` is 1. The full phase-one sequence then replays with identical timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| restart | input | 1 | Synchronous request to replay the bring-up |
| align_done | input | 1 | Lane alignment finished; starts phase two |
| samp_clk_en | output | 1 | Enables the converter's sampling clock |
| adc_reset | output | 1 | Hardware reset pulse to the converter |
| adc_trig | output | 1 | Transmit-trigger pulse to the converter |
| adc_pdn | output | 1 | Power-down pin, held deasserted |
| spi_csn | output | 1 | SPI chip select, active low |
| spi_sclk | output | 1 | SPI serial clock, idle low |
| spi_mosi | output | 1 | SPI serial data to the converter |
| pattern_ready | output | 1 | Deskew pattern active, awaiting alignment |
| normal_ready | output | 1 | Converter back in normal mode |
| busy | output | 1 | Sequence in progress |

## Verification
Each result has a fixed cycle budget, counted from a stimulus edge:
- The reset pulse starts one cycle after the clock enable and lasts exactly the pulse count.
- The first chip-select fall comes one cycle after the reset pulse ends.
- Each frame's chip-select rise is followed by at least `GAP_CYCLES` idle cycles.
- `pattern_ready` rises in the very cycle the trigger falls.
- After `restart`, the outputs are idle in the next cycle.

The monitor samples every output on the falling clock edge. It records the cycle number of each transition and compares the measured widths and distances with these budgets. It decodes every SPI frame at the sampled rising serial-clock edges and pops the expected frame from the scoreboard queue at each chip-select rise.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 16;
  localparam int FRAME_W = ADDR_W + DATA_W;
  localparam int P1_LEN  = 5;
  localparam int IDX_W   = $clog2(P1_LEN);

  typedef enum logic [3:0] {
    ST_OFF, ST_CLK, ST_RST, ST_GO, ST_SHIFT, ST_GAP, ST_TRIG, ST_WAIT, ST_DONE
  } seq_state_t;

  // Frame list: phase one is a fixed ordered table, phase two a single word.
  function automatic logic [FRAME_W-1:0] list_word(input logic ph2,
                                                   input logic [IDX_W-1:0] idx,
                                                   input logic [DATA_W-1:0] nrm);
    logic [FRAME_W-1:0] w;
    if (ph2) begin
      w = {8'h02, nrm};
    end else begin
      case (idx)
        3'd0:    w = {8'h0A, 16'h3000};
        3'd1:    w = {8'h02, 16'h4100};
        3'd2:    w = {8'h03, 16'h0000};
        3'd3:    w = {8'h04, 16'h0000};
        default: w = {8'h01, 16'h0000};
      endcase
    end
    return w;
  endfunction
endpackage

// File: rtl/adcseq_timer.sv
module adcseq_timer #(
  parameter int N = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expire
);
  localparam int W = $clog2(N + 1);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) cnt <= '0;
    else                cnt <= cnt + 1'b1;
  end

  assign expire = run && (cnt == W'(N - 1));

  // R2: a running window never counts past its limit
  a_r2_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    run && $past(run) |-> (cnt != '0) || $past(expire));
endmodule

// File: rtl/adcseq_spi_ser.sv
module adcseq_spi_ser
  import adcseq_pkg::*;
#(
  parameter int SCLK_HALF = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               start,
  input  logic [FRAME_W-1:0] frame,
  output logic               csn,
  output logic               sclk,
  output logic               mosi,
  output logic               done
);
  localparam int DIV_W = (SCLK_HALF > 1) ? $clog2(SCLK_HALF) : 1;
  localparam int BIT_W = $clog2(FRAME_W);

  logic               active;
  logic [FRAME_W-1:0] shreg;
  logic [BIT_W-1:0]   bitcnt;
  logic               half_end;

  generate
    if (SCLK_HALF > 1) begin : g_div
      logic [DIV_W-1:0] div;
      always_ff @(posedge clk) begin
        if (!rst_n || clear || !active || half_end) div <= '0;
        else                                        div <= div + 1'b1;
      end
      assign half_end = active && (div == DIV_W'(SCLK_HALF - 1));
    end else begin : g_nodiv
      assign half_end = active;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      active <= 1'b0;
      sclk   <= 1'b0;
      shreg  <= '0;
      bitcnt <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!active) begin
        if (start) begin
          active <= 1'b1;
          shreg  <= frame;
          bitcnt <= '0;
          sclk   <= 1'b0;
        end
      end else if (half_end) begin
        if (!sclk) begin
          sclk <= 1'b1;
        end else begin
          sclk <= 1'b0;
          if (bitcnt == BIT_W'(FRAME_W - 1)) begin
            active <= 1'b0;
            done   <= 1'b1;
          end else begin
            bitcnt <= bitcnt + 1'b1;
            shreg  <= {shreg[FRAME_W-2:0], 1'b0};
          end
        end
      end
    end
  end

  assign csn  = !active;
  assign mosi = shreg[FRAME_W-1];

  // R3: serial clock idles low whenever the frame is not selected
  a_r3_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    csn |-> !sclk);
  // R3: data does not move while the serial clock is high
  a_r3_mosi_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
    sclk && $past(sclk) |-> $stable(mosi));
  // R3: completion only follows a selected frame
  a_r3_done_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(!csn) && csn);
endmodule

// File: rtl/adc_bringup_seq.sv
module adc_bringup_seq
  import adcseq_pkg::*;
#(
  parameter int          CLKS_PER_MS = 100000,
  parameter int          PULSE_MS    = 10,
  parameter int          SCLK_HALF   = 4,
  parameter int          GAP_CYCLES  = 8,
  parameter logic [15:0] NORMAL_WORD = 16'h0000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic align_done,
  output logic samp_clk_en,
  output logic adc_reset,
  output logic adc_trig,
  output logic adc_pdn,
  output logic spi_csn,
  output logic spi_sclk,
  output logic spi_mosi,
  output logic pattern_ready,
  output logic normal_ready,
  output logic busy
);
  localparam int PULSE_CYC = CLKS_PER_MS * PULSE_MS;

  seq_state_t       st;
  logic [IDX_W-1:0] idx;
  logic             ph2;
  logic             pulse_exp, gap_exp, ser_done;

  adcseq_timer #(.N(PULSE_CYC)) u_pulse_tmr (
    .clk(clk), .rst_n(rst_n),
    .run((st == ST_RST) || (st == ST_TRIG)), .expire(pulse_exp));

  adcseq_timer #(.N(GAP_CYCLES)) u_gap_tmr (
    .clk(clk), .rst_n(rst_n), .run(st == ST_GAP), .expire(gap_exp));

  adcseq_spi_ser #(.SCLK_HALF(SCLK_HALF)) u_ser (
    .clk(clk), .rst_n(rst_n), .clear(restart), .start(st == ST_GO),
    .frame(list_word(ph2, idx, NORMAL_WORD)),
    .csn(spi_csn), .sclk(spi_sclk), .mosi(spi_mosi), .done(ser_done));

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      st  <= ST_OFF;
      idx <= '0;
      ph2 <= 1'b0;
    end else begin
      unique case (st)
        ST_OFF:   st <= ST_CLK;
        ST_CLK:   st <= ST_RST;
        ST_RST:   if (pulse_exp) st <= ST_GO;
        ST_GO:    st <= ST_SHIFT;
        ST_SHIFT: if (ser_done) st <= ST_GAP;
        ST_GAP: if (gap_exp) begin
          if (ph2) begin
            st <= ST_DONE;
          end else if (idx == IDX_W'(P1_LEN - 1)) begin
            idx <= '0;
            st  <= ST_TRIG;
          end else begin
            idx <= idx + 1'b1;
            st  <= ST_GO;
          end
        end
        ST_TRIG:  if (pulse_exp) st <= ST_WAIT;
        ST_WAIT: if (align_done) begin
          ph2 <= 1'b1;
          st  <= ST_GO;
        end
        ST_DONE:  st <= ST_DONE;
        default:  st <= ST_OFF;
      endcase
    end
  end

  assign samp_clk_en   = (st != ST_OFF);
  assign adc_reset     = (st == ST_RST);
  assign adc_trig      = (st == ST_TRIG);
  assign adc_pdn       = 1'b0;
  assign pattern_ready = (st == ST_WAIT);
  assign normal_ready  = (st == ST_DONE);
  assign busy          = !(pattern_ready || normal_ready);

  // R1: the sampling clock is already running when reset is pulsed
  a_r1_clk_before_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_reset) |-> samp_clk_en && $past(samp_clk_en));
  // R4: no frame is in flight while the converter is held in reset
  a_r4_no_frame_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    adc_reset |-> spi_csn);
  // R5: trigger never overlaps a frame
  a_r5_trig_outside_frame: assert property (@(posedge clk) disable iff (!rst_n)
    adc_trig |-> spi_csn);
  // R5: pattern-ready only follows the trigger pulse
  a_r5_ready_after_trig: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pattern_ready) |-> $past(adc_trig));
  // R7: a trigger never follows a reported pattern-ready
  a_r7_no_second_trig: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_trig) |-> !$past(pattern_ready));
  // R8: normal-ready rises with the serial link idle
  a_r8_normal_link_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(normal_ready) |-> spi_csn && $past(spi_csn));
  // R10: restart idles every converter control in the next cycle
  a_r10_restart_idles: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> spi_csn && !samp_clk_en && !adc_reset && !adc_trig);
endmodule

// File: tb/adc_bringup_seq_bench.sv
module adc_bringup_seq_bench;
  localparam int CPM   = 20;
  localparam int PMS   = 10;
  localparam int PULSE = CPM * PMS;
  localparam int HALF  = 2;
  localparam int GAP   = 3;
  localparam logic [15:0] NWORD = 16'h0000;

  logic clk = 1'b0, rst_n = 1'b0, restart = 1'b0, align_done = 1'b0;
  logic samp_clk_en, adc_reset, adc_trig, adc_pdn, spi_csn, spi_sclk, spi_mosi;
  logic pattern_ready, normal_ready, busy;

  always #5 clk = ~clk;

  adc_bringup_seq #(.CLKS_PER_MS(CPM), .PULSE_MS(PMS), .SCLK_HALF(HALF),
                    .GAP_CYCLES(GAP), .NORMAL_WORD(NWORD)) u_adc_bringup_seq (
    .clk(clk), .rst_n(rst_n), .restart(restart), .align_done(align_done),
    .samp_clk_en(samp_clk_en), .adc_reset(adc_reset), .adc_trig(adc_trig),
    .adc_pdn(adc_pdn), .spi_csn(spi_csn), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
    .pattern_ready(pattern_ready), .normal_ready(normal_ready), .busy(busy));

  int tests = 0, fails = 0;
  bit finished = 1'b0;
  logic [23:0] exp_q[$];

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push_phase1();
    exp_q.push_back({8'h0A, 16'h3000});
    exp_q.push_back({8'h02, 16'h4100});
    exp_q.push_back({8'h03, 16'h0000});
    exp_q.push_back({8'h04, 16'h0000});
    exp_q.push_back({8'h01, 16'h0000});
  endtask

  // ---------------- monitor / scoreboard ----------------
  longint cyc = 0, clk_rise_cyc = 0, csn_rise_cyc = 0;
  int rst_w = 0, trig_w = 0, hi_w = 0, bits = 0, frames = 0, trig_rises = 0, pdn_bad = 0;
  int frames_since_rst = 0;
  bit gap_armed = 1'b0;
  logic [23:0] sh = '0;
  logic p_en = 0, p_rst = 0, p_trig = 0, p_csn = 1, p_sclk = 0, p_pat = 0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (adc_pdn) pdn_bad++;
      if (samp_clk_en && !p_en) clk_rise_cyc = cyc;
      if (adc_reset && !p_rst) begin
        check(cyc - clk_rise_cyc == 1, "R1 reset one cycle after clock enable", cyc - clk_rise_cyc, 1);
        rst_w = 0;
        frames_since_rst = 0;
      end
      if (adc_reset) rst_w++;
      if (!adc_reset && p_rst) check(rst_w == PULSE, "R2 reset width", rst_w, PULSE);
      if (adc_trig && !p_trig) begin
        trig_rises++;
        trig_w = 0;
        check(frames_since_rst == 5 && spi_csn, "R5 trigger after five frames", frames_since_rst, 5);
      end
      if (adc_trig) trig_w++;
      if (!adc_trig && p_trig) begin
        check(trig_w == PULSE, "R5 trigger width", trig_w, PULSE);
        check(pattern_ready, "R5 pattern_ready with trigger fall", pattern_ready, 1);
      end
      if (pattern_ready && !p_pat) gap_armed = 1'b0;
      if (!spi_csn && p_csn) begin
        bits = 0;
        check(!adc_reset, "R4 frame after reset", adc_reset, 0);
        if (gap_armed) check(cyc - csn_rise_cyc >= GAP, "R4 inter-frame gap", cyc - csn_rise_cyc, GAP);
      end
      if (spi_sclk && !p_sclk && !spi_csn) begin
        sh = {sh[22:0], spi_mosi};
        bits++;
        hi_w = 0;
      end
      if (spi_sclk) hi_w++;
      if (!spi_sclk && p_sclk) check(hi_w == HALF, "R3 sclk high phase", hi_w, HALF);
      if (spi_csn && !p_csn) begin
        csn_rise_cyc = cyc;
        gap_armed = 1'b1;
        frames++;
        frames_since_rst++;
        if (exp_q.size() == 0) begin
          check(1'b0, "R4 unexpected frame", sh, 0);
        end else begin
          logic [23:0] e;
          e = exp_q.pop_front();
          check(sh == e && bits == 24, "R3 R4 frame content", {bits[7:0], sh}, {8'd24, e});
        end
      end
    end
    p_en = samp_clk_en; p_rst = adc_reset; p_trig = adc_trig;
    p_csn = spi_csn; p_sclk = spi_sclk; p_pat = pattern_ready;
  end

  task automatic wait_sig(input int which, input int limit);
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (which == 0 && pattern_ready) return;
      if (which == 1 && normal_ready) return;
    end
    check(1'b0, "timeout waiting for ready", which, 1);
  endtask

  task automatic pulse_align();
    @(posedge clk); #1 align_done = 1'b1;
    @(posedge clk); #1 align_done = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check(!samp_clk_en && !adc_reset && !adc_trig && !spi_sclk, "R1 reset outputs low",
          {samp_clk_en, adc_reset, adc_trig, spi_sclk}, 0);
    check(spi_csn && busy && !pattern_ready && !normal_ready, "R1 reset csn busy ready",
          {spi_csn, busy, pattern_ready, normal_ready}, 3'b110 << 1);
    push_phase1();
    @(posedge clk); #1 rst_n = 1'b1;
    // stray align_done during the reset pulse (R6)
    repeat (40) @(posedge clk);
    #1 align_done = 1'b1;
    @(posedge clk); #1 align_done = 1'b0;
    wait_sig(0, 5000);
    check(frames == 5 && exp_q.size() == 0, "R4 five phase-one frames", frames, 5);
    check(!busy, "R8 busy low with pattern_ready", busy, 0);
    repeat (30) @(negedge clk);
    check(pattern_ready && frames == 5, "R6 stray align_done ignored", frames, 5);
    exp_q.push_back({8'h02, NWORD});
    pulse_align();
    @(negedge clk);
    check(!pattern_ready && busy, "R7 pattern_ready drops", {pattern_ready, busy}, 1);
    wait_sig(1, 5000);
    check(frames == 6 && exp_q.size() == 0, "R7 one phase-two frame", frames, 6);
    check(trig_rises == 1, "R7 no second trigger", trig_rises, 1);
    check(!busy && spi_csn, "R8 normal_ready idle", {busy, spi_csn}, 1);
    pulse_align();
    repeat (60) @(negedge clk);
    check(normal_ready && frames == 6, "R6 align_done ignored when done", frames, 6);
    push_phase1();
    @(posedge clk); #1 restart = 1'b1;
    @(posedge clk); #1 restart = 1'b0;
    @(negedge clk);
    check(!samp_clk_en && spi_csn && busy && !normal_ready, "R10 restart idles",
          {samp_clk_en, spi_csn, busy, normal_ready}, 4'b0110);
    wait_sig(0, 5000);
    check(frames == 11 && exp_q.size() == 0 && trig_rises == 2, "R10 sequence replays", frames, 11);
    check(pdn_bad == 0, "R9 power-down never asserted", pdn_bad, 0);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule